// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the arbitration core of an eight-input interrupt controller. It captures requests from eight interrupt lines, either on rising edges or by following the line level, filters them through a mask, and compares the best pending request with the levels already in service. When a pending request outranks everything in service, it raises a single interrupt line toward the processor. A one-cycle acknowledge pulse returns an 8-bit vector, made of a configured base and the winning level number, and moves that request into service.

Priority is rotating. A 3-bit pointer names the lowest-priority level, and the level just after it, modulo 8, has the highest priority. After reset the pointer is 7, so input 0 has the highest priority. Software ends service and moves the pointer through a one-cycle command strobe that carries a 3-bit code and a 3-bit level. An automatic end-of-service mode can clear service at acknowledge time, and it can optionally rotate priority as well. Mask, trigger mode, vector base and automatic end-of-service are static configuration inputs, driven by a register decode outside this block.

Top module: `irq_resolver`

## Requirements
- R1: After reset, no request or in-service bit is set, the priority pointer is 7 (input 0 highest, input 7 lowest), automatic rotation is off, `int_o` is 0 and `vector_o` is {base, 3'd7}.
- R2: In edge mode (`level_mode_i`=0), a 0-to-1 change on `irq_i[n]` sets request n at the next clock edge, and `int_o` can assert in that same cycle. Acknowledging request n clears it. An input that stays high does not raise request n again.
- R3: In level mode (`level_mode_i`=1), request n is the value `irq_i[n]` had at the previous clock edge. Acknowledge does not clear it.
- R4: A request whose `mask_i` bit is 1 never drives `int_o` or the vector. The request is still held, and it takes part in arbitration once its mask bit is 0.
- R5: The rank of level n is (n - pointer - 1) mod 8, where rank 0 is the highest priority. `vector_o` is {`vec_base_i` in bits 7..3, winning level in bits 2..0}.
- R6: `int_o` is 1 when an unmasked request exists whose rank is strictly better than the best in-service rank (or nothing is in service). On an acknowledge (`inta_i`=1 with `int_o`=1), the winner's in-service bit is set at that clock edge, and `int_o` is re-evaluated in the next cycle.
- R7: An acknowledge while `int_o` is 0 returns {base, 3'd7} and changes no in-service bit.
- R8: Command code 3'b001 clears the in-service bit with the best rank. Code 3'b011 clears the in-service bit named by `cmd_level_i`.
- R9: Code 3'b101 works like 3'b001 and also moves the pointer to the level it cleared. Code 3'b111 works like 3'b011 and also moves the pointer to `cmd_level_i`.
- R10: Code 3'b110 moves the pointer to `cmd_level_i` and clears nothing. Code 3'b010 changes nothing.
- R11: With `auto_eoi_i`=1, an acknowledge sets no in-service bit. Code 3'b100 turns on automatic rotation and code 3'b000 turns it off. While automatic rotation is on, each acknowledge in this mode moves the pointer to the acknowledged level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines |
| mask_i | input | 8 | Per-line mask, 1 = inhibited |
| level_mode_i | input | 1 | 1 = level-sensitive, 0 = rising-edge capture |
| vec_base_i | input | 5 | Upper vector bits |
| auto_eoi_i | input | 1 | Clear service automatically at acknowledge |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_code_i | input | 3 | Service / priority command code |
| cmd_level_i | input | 3 | Level operand of the command |
| inta_i | input | 1 | One-cycle acknowledge pulse |
| int_o | output | 1 | Interrupt to processor |
| vector_o | output | 8 | Vector, valid in the acknowledge cycle |

## Verification
The bench aims at the nesting rules. It checks that a lower or equal level stays blocked behind a level in service, and that a higher level still breaks through. A comparison that used "at or above" instead of "strictly above" would either hide the preempting request or let equal levels re-enter. Rotation is checked by placing two requests at once on either side of the moved pointer, so a pointer that moved to the wrong level, or did not move at all, returns the other vector. The checks of the no-op code, the spurious acknowledge and automatic end-of-service read back the hidden in-service state through `int_o`. A design that wrongly set or cleared an in-service bit would then show a line asserting or staying quiet when it should not.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  localparam logic [2:0] CMD_AROT_OFF = 3'b000;
  localparam logic [2:0] CMD_EOI_NS   = 3'b001;
  localparam logic [2:0] CMD_NOP      = 3'b010;
  localparam logic [2:0] CMD_EOI_SP   = 3'b011;
  localparam logic [2:0] CMD_AROT_ON  = 3'b100;
  localparam logic [2:0] CMD_ROT_NS   = 3'b101;
  localparam logic [2:0] CMD_SET_LOW  = 3'b110;
  localparam logic [2:0] CMD_ROT_SP   = 3'b111;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic [NUM_IRQ-1:0] ack_clr_i,
  output logic [NUM_IRQ-1:0] req_o
);
  logic [NUM_IRQ-1:0] prev_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= irq_i;
      if (level_mode_i) req_q <= irq_i;
      else              req_q <= (req_q & ~ack_clr_i) | (irq_i & ~prev_q);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Rotating priority encoder: rank 0 is the level just after ptr_i.
module irq_prio_pick #(
  parameter int NUM_IRQ = 8,
  localparam int LVL_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  input  logic [LVL_W-1:0]   ptr_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [LVL_W-1:0]   rank_o
);
  logic [LVL_W-1:0] idx;

  always_comb begin
    any_o = 1'b0;
    lvl_o = '0;
    idx   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      idx = ptr_i + LVL_W'(1) + LVL_W'(i);
      if (vec_i[idx]) begin
        any_o = 1'b1;
        lvl_o = idx;
      end
    end
    rank_o = lvl_o - ptr_i - LVL_W'(1);
  end
endmodule

// File: rtl/irq_svc_ctrl.sv
module irq_svc_ctrl
  import irq_core_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int LVL_W = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ack_take_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  input  logic               auto_eoi_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [LVL_W-1:0]   cmd_level_i,
  input  logic               top_any_i,
  input  logic [LVL_W-1:0]   top_lvl_i,
  output logic [NUM_IRQ-1:0] isr_o,
  output logic [LVL_W-1:0]   ptr_o
);
  logic [NUM_IRQ-1:0] isr_q, isr_set, isr_clr;
  logic [LVL_W-1:0]   ptr_q, ptr_d;
  logic               arot_q, arot_d;

  always_comb begin
    isr_set = '0;
    isr_clr = '0;
    ptr_d   = ptr_q;
    arot_d  = arot_q;
    if (ack_take_i) begin
      if (!auto_eoi_i)  isr_set[ack_lvl_i] = 1'b1;
      else if (arot_q)  ptr_d = ack_lvl_i;
    end
    if (cmd_valid_i) begin
      unique case (cmd_code_i)
        CMD_EOI_NS: if (top_any_i) isr_clr[top_lvl_i] = 1'b1;
        CMD_EOI_SP: isr_clr[cmd_level_i] = 1'b1;
        CMD_ROT_NS: if (top_any_i) begin
          isr_clr[top_lvl_i] = 1'b1;
          ptr_d = top_lvl_i;
        end
        CMD_ROT_SP: begin
          isr_clr[cmd_level_i] = 1'b1;
          ptr_d = cmd_level_i;
        end
        CMD_SET_LOW:  ptr_d  = cmd_level_i;
        CMD_AROT_ON:  arot_d = 1'b1;
        CMD_AROT_OFF: arot_d = 1'b0;
        CMD_NOP:      ;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      ptr_q  <= LVL_W'(NUM_IRQ - 1);
      arot_q <= 1'b0;
    end else begin
      isr_q  <= (isr_q & ~isr_clr) | isr_set;
      ptr_q  <= ptr_d;
      arot_q <= arot_d;
    end
  end

  assign isr_o = isr_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int NUM_IRQ = 8,
  parameter int BASE_W  = 5,
  localparam int LVL_W = $clog2(NUM_IRQ),
  localparam int VEC_W = BASE_W + LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic               level_mode_i,
  input  logic [BASE_W-1:0]  vec_base_i,
  input  logic               auto_eoi_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [LVL_W-1:0]   cmd_level_i,
  input  logic               inta_i,
  output logic               int_o,
  output logic [VEC_W-1:0]   vector_o
);
  logic [NUM_IRQ-1:0] req_q, isr_q, elig, ack_clr;
  logic [LVL_W-1:0]   ptr_q, win_lvl, win_rank, top_lvl, top_rank;
  logic               win_any, top_any, ack_take;

  irq_req_latch #(.NUM_IRQ(NUM_IRQ)) i_req (
    .clk_i, .rst_ni, .irq_i, .level_mode_i,
    .ack_clr_i (ack_clr),
    .req_o     (req_q)
  );

  assign elig = req_q & ~mask_i;

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) i_pend_pick (
    .vec_i (elig), .ptr_i (ptr_q),
    .any_o (win_any), .lvl_o (win_lvl), .rank_o (win_rank)
  );

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) i_svc_pick (
    .vec_i (isr_q), .ptr_i (ptr_q),
    .any_o (top_any), .lvl_o (top_lvl), .rank_o (top_rank)
  );

  // strictly better than every level in service
  assign int_o    = win_any && (!top_any || (win_rank < top_rank));
  assign ack_take = inta_i && int_o;

  always_comb begin
    ack_clr = '0;
    if (ack_take) ack_clr[win_lvl] = 1'b1;
  end

  assign vector_o = {vec_base_i, int_o ? win_lvl : LVL_W'(NUM_IRQ - 1)};

  irq_svc_ctrl #(.NUM_IRQ(NUM_IRQ)) i_svc (
    .clk_i, .rst_ni,
    .ack_take_i  (ack_take),
    .ack_lvl_i   (win_lvl),
    .auto_eoi_i,
    .cmd_valid_i, .cmd_code_i, .cmd_level_i,
    .top_any_i   (top_any),
    .top_lvl_i   (top_lvl),
    .isr_o       (isr_q),
    .ptr_o       (ptr_q)
  );
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W = $clog2(NUM_IRQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic [NUM_IRQ-1:0] mask_i,
  input logic               level_mode_i,
  input logic               auto_eoi_i,
  input logic               cmd_valid_i,
  input logic [2:0]         cmd_code_i,
  input logic [LVL_W-1:0]   cmd_level_i,
  input logic               inta_i,
  input logic               int_o,
  input logic [VEC_W-1:0]   vector_o,
  input logic [NUM_IRQ-1:0] req_q,
  input logic [NUM_IRQ-1:0] isr_q,
  input logic [LVL_W-1:0]   ptr_q
);
  // R4
  int_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(req_q & ~mask_i)));

  // R3
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i |=> (req_q == $past(irq_i)));

  // R6
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !auto_eoi_i && !cmd_valid_i) |=> isr_q[$past(vector_o[LVL_W-1:0])]);

  // R7
  spurious_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |-> (vector_o[LVL_W-1:0] == LVL_W'(NUM_IRQ - 1)));

  // R7
  spurious_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !cmd_valid_i) |=> $stable(isr_q));

  // R8
  spec_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_code_i == 3'b011 && !inta_i) |=> !isr_q[$past(cmd_level_i)]);

  // R10
  nop_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_code_i == 3'b010 && !inta_i) |=> ($stable(isr_q) && $stable(ptr_q)));

  // R11
  aeoi_no_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && auto_eoi_i && !cmd_valid_i) |=> $stable(isr_q));
endmodule

bind irq_resolver irq_resolver_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .mask_i(mask_i),
  .level_mode_i(level_mode_i), .auto_eoi_i(auto_eoi_i),
  .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .cmd_level_i(cmd_level_i),
  .inta_i(inta_i), .int_o(int_o), .vector_o(vector_o),
  .req_q(req_q), .isr_q(isr_q), .ptr_q(ptr_q)
);

// File: tb/test_irq_resolver.sv
module test_irq_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq, mask;
  logic       lvl_mode, aeoi, cvalid, inta;
  logic [4:0] base;
  logic [2:0] ccode, clevel;
  logic       int_w;
  logic [7:0] vec;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  irq_resolver i_irq_resolver (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mask_i(mask),
    .level_mode_i(lvl_mode), .vec_base_i(base), .auto_eoi_i(aeoi),
    .cmd_valid_i(cvalid), .cmd_code_i(ccode), .cmd_level_i(clevel),
    .inta_i(inta), .int_o(int_w), .vector_o(vec)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    irq = '0; mask = '0; lvl_mode = 0; aeoi = 0; cvalid = 0; inta = 0;
    ccode = '0; clevel = '0; base = 5'h08;
    rst_n = 0;
    repeat (2) step();
    rst_n = 1;
    step();
  endtask

  task automatic ack(input string tag, input logic [7:0] exp);
    inta = 1;
    chk(tag, vec, exp);
    step();
    inta = 0;
  endtask

  task automatic cmd(input logic [2:0] c, input logic [2:0] l);
    cvalid = 1; ccode = c; clevel = l;
    step();
    cvalid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 int idle", {7'd0, int_w}, 8'h01 & 8'h00);
    chk("R1 idle vector", vec, 8'h47);
  endtask

  task automatic t_edge();
    do_reset();
    irq = 8'h08; step();
    chk("R2 int after rise", {7'd0, int_w}, 8'h01);
    ack("R5 vector lvl3", 8'h43);
    chk("R6 int drops after ack", {7'd0, int_w}, 8'h00);
    cmd(3'b001, 3'd0);
    chk("R2 held high no retrigger", {7'd0, int_w}, 8'h00);
    irq = 8'h00; step();
    irq = 8'h08; step();
    chk("R2 new rise", {7'd0, int_w}, 8'h01);
  endtask

  task automatic t_nest();
    do_reset();
    irq = 8'h28; step();
    ack("R5 lvl3 beats lvl5", 8'h43);
    chk("R6 lower blocked", {7'd0, int_w}, 8'h00);
    irq = 8'h2A; step();
    chk("R6 higher preempts", vec, 8'h41);
    ack("R6 ack lvl1", 8'h41);
    cmd(3'b001, 3'd0);
    chk("R8 ns eoi keeps lvl3", {7'd0, int_w}, 8'h00);
    cmd(3'b001, 3'd0);
    chk("R8 ns eoi clears lvl3", vec, 8'h45);
  endtask

  task automatic t_mask();
    do_reset();
    mask = 8'h04; irq = 8'h04; step();
    chk("R4 masked no int", {7'd0, int_w}, 8'h00);
    chk("R4 masked vector", vec, 8'h47);
    mask = 8'h00; #1;
    chk("R4 held request", vec, 8'h42);
  endtask

  task automatic t_level();
    do_reset();
    lvl_mode = 1; irq = 8'h40; step();
    chk("R3 level int", vec, 8'h46);
    irq = 8'h00; step();
    chk("R3 level drop", {7'd0, int_w}, 8'h00);
    irq = 8'h40; step();
    ack("R3 level ack", 8'h46);
    chk("R6 in service blocks", {7'd0, int_w}, 8'h00);
    cmd(3'b001, 3'd0);
    chk("R3 level request stays", {7'd0, int_w}, 8'h01);
  endtask

  task automatic t_spurious();
    do_reset();
    lvl_mode = 1; irq = 8'h10; step();
    irq = 8'h00; step();
    ack("R7 spurious vector", 8'h47);
    irq = 8'h80; step();
    chk("R7 no isr set", {7'd0, int_w}, 8'h01);
  endtask

  task automatic t_spec_eoi();
    do_reset();
    irq = 8'h04; step();
    ack("R5 lvl2", 8'h42);
    irq = 8'h05; step();
    ack("R6 lvl0 preempts", 8'h40);
    cmd(3'b011, 3'd2);
    irq = 8'h0D; step();
    chk("R8 lvl0 still blocks", {7'd0, int_w}, 8'h00);
    cmd(3'b011, 3'd0);
    chk("R8 specific eoi clears both", vec, 8'h43);
  endtask

  task automatic t_rotate();
    do_reset();
    irq = 8'h04; step();
    ack("R9 lvl2", 8'h42);
    cmd(3'b101, 3'd0);
    irq = 8'h16; step();
    chk("R9 rotate ns moves ptr", vec, 8'h44);
    ack("R9 ack lvl4", 8'h44);
    cmd(3'b111, 3'd4);
    irq = 8'h56; step();
    chk("R9 rotate specific", vec, 8'h46);
  endtask

  task automatic t_setprio();
    do_reset();
    cmd(3'b110, 3'd0);
    irq = 8'h81; step();
    chk("R10 set lowest", vec, 8'h47);
    ack("R10 ack lvl7", 8'h47);
    cmd(3'b010, 3'd0);
    chk("R10 nop no eoi", {7'd0, int_w}, 8'h00);
    cmd(3'b001, 3'd0);
    chk("R10 after eoi", vec, 8'h40);
  endtask

  task automatic t_aeoi();
    do_reset();
    aeoi = 1;
    irq = 8'h20; step();
    ack("R11 aeoi lvl5", 8'h45);
    irq = 8'h40; step();
    chk("R11 no isr left", vec, 8'h46);
    ack("R11 ack lvl6", 8'h46);
    cmd(3'b100, 3'd0);
    irq = 8'h08; step();
    ack("R11 ack lvl3", 8'h43);
    irq = 8'h14; step();
    chk("R11 rotated to 3", vec, 8'h44);
    ack("R11 ack lvl4", 8'h44);
    cmd(3'b000, 3'd0);
    irq = 8'h21; step();
    ack("R11 ptr at 4", 8'h45);
    irq = 8'h00; step();
    irq = 8'h60; step();
    chk("R11 rotation off", vec, 8'h45);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_nest();
    t_mask();
    t_level();
    t_spurious();
    t_spec_eoi();
    t_rotate();
    t_setprio();
    t_aeoi();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule